// File: doc/BRIEF.md
# JTAG Scan Command Engine

This block is a JTAG master that sits next to a host controller and turns whole test-access-port commands into pin activity. It drives the scan clock, mode-select and serial-in lines and samples the serial-out line from the chain. Four commands are supported: bring the TAP to a known state, scan the instruction register, scan a data register, and hold the TAP in Run-Test/Idle for a number of scan-clock cycles.

For a scan the host gives a bit count, the pattern to shift in, an expected pattern and a compare mask. The engine walks the TAP to the right shift state and shifts the bits least significant first. It then goes back to Run-Test/Idle and reports the captured bits together with a pass flag. The scan clock is made from the system clock by a divider. All sequencing, counting and comparing runs in the system clock domain, and the scan clock itself is treated as a data output.

Top module: `jtag_scan_engine`

## Requirements
- R1: A command is taken when `cmd_valid_i` and `cmd_ready_o` are both high. `cmd_ready_o` is low from the cycle after acceptance until the command finishes. Each accepted command ends with exactly one single-cycle `done_o` pulse. After reset `cmd_ready_o`=1, `done_o`=0, `tck_o`=0 and `tdo_vec_o`=0.
- R2: Each high phase and each low phase of `tck_o` lasts HALF_CLKS system clocks. `tms_o` and `tdi_o` change only in cycles where `tck_o` is low.
- R3: Reset command (`cmd_op_i`=0): TMS is 1 for five rising edges of `tck_o` and then 0 for one, which makes six scan-clock cycles in total. `pass_o`=1.
- R4: Instruction scan (`cmd_op_i`=1) of length N sends TMS 1,1,0,0, then N shift cycles whose last one has TMS 1, then 1,0: N+6 cycles in total. Data scan (`cmd_op_i`=2) sends 1,0,0, then the N shift cycles, then 1,0: N+5 cycles in total.
- R5: In shift cycle k the value on `tdi_o` is bit k of `cmd_tdi_i`. `tdi_o` is 0 on every rising edge outside the shift cycles.
- R6: The value on `tdo_i` in the high phase of shift cycle k is sampled at that cycle's falling edge and stored in bit k of `tdo_vec_o`. Bits N and above read 0.
- R7: For a scan, `pass_o`=1 exactly when no bit k<N has `cmd_mask_i[k]`=1 and a captured bit that differs from `cmd_exp_i[k]`. Bits where the mask is 0 never affect `pass_o`.
- R8: Run-test (`cmd_op_i`=3) with count M gives exactly M scan-clock cycles with TMS 0 and `pass_o`=1. M=0 finishes with no scan-clock edge. Counts up to 2^RUN_W-1 are held.
- R9: A scan or run-test that is issued before a reset command has completed, or a scan with N=0 or N>MAX_LEN, is rejected. It produces no scan-clock edge and finishes with `pass_o`=0.
- R10: Every reset, scan or run-test that is not rejected leaves the target TAP in Run-Test/Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Engine can take a command |
| cmd_op_i | input | 2 | 0 reset, 1 instruction scan, 2 data scan, 3 run-test |
| cmd_len_i | input | LEN_W | Scan length N in bits |
| cmd_count_i | input | RUN_W | Run-test cycle count M |
| cmd_tdi_i | input | MAX_LEN | Pattern shifted in, bit 0 first |
| cmd_exp_i | input | MAX_LEN | Expected captured pattern |
| cmd_mask_i | input | MAX_LEN | 1 marks a compared bit |
| done_o | output | 1 | Single-cycle completion pulse |
| pass_o | output | 1 | Result of the finished command |
| tdo_vec_o | output | MAX_LEN | Captured bits of the last scan |
| tck_o | output | 1 | Scan clock |
| tms_o | output | 1 | Mode select |
| tdi_o | output | 1 | Serial data to the chain |
| tdo_i | input | 1 | Serial data from the chain |

## Verification
The bench builds the engine with MAX_LEN=40 and HALF_CLKS=3, and keeps RUN_W at 24. A three-clock half period shows that the divider holds every phase for the full count and does not simply toggle. A 40-bit maximum lets the bench run a full-length scan and the over-length rejection within a short run. RUN_W=24 keeps a count of fifteen million within range, but the bench only drives waits of up to a thousand cycles. A target TAP model in the bench replays a chosen serial-out stream and logs every mode-select and serial-in bit it clocks.

// File: rtl/jtag_eng_pkg.sv
package jtag_eng_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_IR    = 2'd1,
    OP_DR    = 2'd2,
    OP_RUN   = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    TAP_TLR, TAP_IDLE,
    TAP_SEL_DR, TAP_CAP_DR, TAP_SH_DR, TAP_EX1_DR, TAP_PAU_DR, TAP_EX2_DR, TAP_UPD_DR,
    TAP_SEL_IR, TAP_CAP_IR, TAP_SH_IR, TAP_EX1_IR, TAP_PAU_IR, TAP_EX2_IR, TAP_UPD_IR
  } tap_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_RESET, PH_PRE, PH_SHIFT, PH_POST, PH_WAIT, PH_COMPL
  } phase_e;

  localparam int unsigned RESET_ONES = 5;

  function automatic tap_e tap_next(tap_e s, logic tms);
    case (s)
      TAP_TLR:    return tms ? TAP_TLR    : TAP_IDLE;
      TAP_IDLE:   return tms ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_DR: return tms ? TAP_SEL_IR : TAP_CAP_DR;
      TAP_CAP_DR: return tms ? TAP_EX1_DR : TAP_SH_DR;
      TAP_SH_DR:  return tms ? TAP_EX1_DR : TAP_SH_DR;
      TAP_EX1_DR: return tms ? TAP_UPD_DR : TAP_PAU_DR;
      TAP_PAU_DR: return tms ? TAP_EX2_DR : TAP_PAU_DR;
      TAP_EX2_DR: return tms ? TAP_UPD_DR : TAP_SH_DR;
      TAP_UPD_DR: return tms ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_IR: return tms ? TAP_TLR    : TAP_CAP_IR;
      TAP_CAP_IR: return tms ? TAP_EX1_IR : TAP_SH_IR;
      TAP_SH_IR:  return tms ? TAP_EX1_IR : TAP_SH_IR;
      TAP_EX1_IR: return tms ? TAP_UPD_IR : TAP_PAU_IR;
      TAP_PAU_IR: return tms ? TAP_EX2_IR : TAP_PAU_IR;
      TAP_EX2_IR: return tms ? TAP_UPD_IR : TAP_SH_IR;
      default:    return tms ? TAP_SEL_DR : TAP_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/jtag_tck_div.sv
module jtag_tck_div #(
  parameter int unsigned HALF_CLKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned DIV_W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

  logic [DIV_W-1:0] cnt_q;
  logic             tck_q;
  logic             edge_w;

  assign edge_w = en_i && (cnt_q == DIV_W'(HALF_CLKS - 1));
  assign rise_o = edge_w && !tck_q;
  assign fall_o = edge_w && tck_q;
  assign tck_o  = tck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      tck_q <= 1'b0;
    end else if (edge_w) begin
      cnt_q <= '0;
      tck_q <= ~tck_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  a_r2_park_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tck_o);

endmodule

// File: rtl/jtag_tap_track.sv
module jtag_tap_track
  import jtag_eng_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic tms_i,
  output tap_e state_o,
  output logic known_o
);
  tap_e       state_q;
  logic [2:0] ones_q;
  logic       known_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TAP_TLR;
      ones_q  <= '0;
      known_q <= 1'b0;
    end else if (step_i) begin
      state_q <= tap_next(state_q, tms_i);
      if (tms_i) begin
        if (ones_q < 3'(RESET_ONES)) ones_q <= ones_q + 3'd1;
        if (ones_q == 3'(RESET_ONES - 1)) known_q <= 1'b1;
      end else begin
        ones_q <= '0;
      end
    end
  end

  assign state_o = state_q;
  assign known_o = known_q;

  a_r3_known_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(known_o) |-> state_o == TAP_TLR);

endmodule

// File: rtl/jtag_tdo_cmp.sv
module jtag_tdo_cmp #(
  parameter int unsigned MAX_LEN = 64,
  parameter int unsigned LEN_W   = 7
) (
  input  logic [MAX_LEN-1:0] cap_i,
  input  logic [MAX_LEN-1:0] exp_i,
  input  logic [MAX_LEN-1:0] mask_i,
  input  logic [LEN_W-1:0]   len_i,
  output logic               match_o
);
  logic [MAX_LEN-1:0] valid_w;

  for (genvar i = 0; i < MAX_LEN; i++) begin : g_valid
    assign valid_w[i] = LEN_W'(i) < len_i;
  end

  assign match_o = ~|((cap_i ^ exp_i) & mask_i & valid_w);

endmodule

// File: rtl/jtag_scan_engine.sv
module jtag_scan_engine
  import jtag_eng_pkg::*;
#(
  parameter int unsigned MAX_LEN   = 64,
  parameter int unsigned HALF_CLKS = 4,
  parameter int unsigned RUN_W     = 24,
  localparam int unsigned LEN_W    = $clog2(MAX_LEN + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic [1:0]         cmd_op_i,
  input  logic [LEN_W-1:0]   cmd_len_i,
  input  logic [RUN_W-1:0]   cmd_count_i,
  input  logic [MAX_LEN-1:0] cmd_tdi_i,
  input  logic [MAX_LEN-1:0] cmd_exp_i,
  input  logic [MAX_LEN-1:0] cmd_mask_i,
  output logic               done_o,
  output logic               pass_o,
  output logic [MAX_LEN-1:0] tdo_vec_o,
  output logic               tck_o,
  output logic               tms_o,
  output logic               tdi_o,
  input  logic               tdo_i
);
  localparam int unsigned IDX_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
  localparam int unsigned CNT_W = (RUN_W > LEN_W) ? RUN_W : LEN_W;

  phase_e             phase_q;
  op_e                op_q;
  logic [CNT_W-1:0]   cnt_q, cnt_nx, cnt_nx2, len_ext, run_ext;
  logic [LEN_W-1:0]   len_q;
  logic [RUN_W-1:0]   run_q;
  logic [MAX_LEN-1:0] tdi_vec_q, exp_q, mask_q, cap_q;
  logic               rej_q, tms_q, tdi_q, tck_en_q, done_q, pass_q;
  logic               rise_w, fall_w, tck_w, match_w, tap_known, at_idle, len_ok;
  tap_e               tap_state;
  logic [3:0]         pre_pat;
  logic [1:0]         pre_last;
  logic [IDX_W-1:0]   idx_c, idx_n;

  jtag_tck_div #(.HALF_CLKS(HALF_CLKS)) u_div (
    .clk_i, .rst_ni, .en_i(tck_en_q), .tck_o(tck_w), .rise_o(rise_w), .fall_o(fall_w)
  );

  jtag_tap_track u_track (
    .clk_i, .rst_ni, .step_i(rise_w), .tms_i(tms_q), .state_o(tap_state), .known_o(tap_known)
  );

  jtag_tdo_cmp #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_cmp (
    .cap_i(cap_q), .exp_i(exp_q), .mask_i(mask_q), .len_i(len_q), .match_o(match_w)
  );

  assign cnt_nx   = cnt_q + CNT_W'(1);
  assign cnt_nx2  = cnt_q + CNT_W'(2);
  assign len_ext  = CNT_W'(len_q);
  assign run_ext  = CNT_W'(run_q);
  assign idx_c    = cnt_q[IDX_W-1:0];
  assign idx_n    = cnt_nx[IDX_W-1:0];
  assign at_idle  = tap_known && (tap_state == TAP_IDLE);
  assign len_ok   = (cmd_len_i != '0) && (cmd_len_i <= LEN_W'(MAX_LEN));
  // TMS preamble from Run-Test/Idle, bit 0 first
  assign pre_pat  = (op_q == OP_IR) ? 4'b0011 : 4'b0001;
  assign pre_last = (op_q == OP_IR) ? 2'd3 : 2'd2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      op_q      <= OP_RESET;
      cnt_q     <= '0;
      len_q     <= '0;
      run_q     <= '0;
      tdi_vec_q <= '0;
      exp_q     <= '0;
      mask_q    <= '0;
      cap_q     <= '0;
      rej_q     <= 1'b0;
      tms_q     <= 1'b0;
      tdi_q     <= 1'b0;
      tck_en_q  <= 1'b0;
      done_q    <= 1'b0;
      pass_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (cmd_valid_i) begin
          op_q      <= op_e'(cmd_op_i);
          len_q     <= cmd_len_i;
          run_q     <= cmd_count_i;
          tdi_vec_q <= cmd_tdi_i;
          exp_q     <= cmd_exp_i;
          mask_q    <= cmd_mask_i;
          cap_q     <= '0;
          cnt_q     <= '0;
          rej_q     <= 1'b0;
          case (op_e'(cmd_op_i))
            OP_RESET: begin
              phase_q  <= PH_RESET;
              tms_q    <= 1'b1;
              tck_en_q <= 1'b1;
            end
            OP_IR, OP_DR: begin
              if (at_idle && len_ok) begin
                phase_q  <= PH_PRE;
                tms_q    <= 1'b1;
                tck_en_q <= 1'b1;
              end else begin
                rej_q   <= 1'b1;
                phase_q <= PH_COMPL;
              end
            end
            default: begin
              if (!at_idle) begin
                rej_q   <= 1'b1;
                phase_q <= PH_COMPL;
              end else if (cmd_count_i == '0) begin
                phase_q <= PH_COMPL;
              end else begin
                phase_q  <= PH_WAIT;
                tms_q    <= 1'b0;
                tck_en_q <= 1'b1;
              end
            end
          endcase
        end
        PH_RESET: if (fall_w) begin
          if (cnt_q == CNT_W'(RESET_ONES)) begin
            phase_q  <= PH_COMPL;
            tck_en_q <= 1'b0;
            tms_q    <= 1'b0;
          end else begin
            cnt_q <= cnt_nx;
            tms_q <= cnt_nx < CNT_W'(RESET_ONES);
          end
        end
        PH_PRE: if (fall_w) begin
          if (cnt_q[1:0] == pre_last) begin
            phase_q <= PH_SHIFT;
            cnt_q   <= '0;
            tms_q   <= len_q == LEN_W'(1);
            tdi_q   <= tdi_vec_q[0];
          end else begin
            cnt_q <= cnt_nx;
            tms_q <= pre_pat[cnt_nx[1:0]];
          end
        end
        PH_SHIFT: if (fall_w) begin
          cap_q[idx_c] <= tdo_i;
          if (cnt_nx == len_ext) begin
            phase_q <= PH_POST;
            cnt_q   <= '0;
            tms_q   <= 1'b1;
            tdi_q   <= 1'b0;
          end else begin
            cnt_q <= cnt_nx;
            tdi_q <= tdi_vec_q[idx_n];
            tms_q <= cnt_nx2 == len_ext;
          end
        end
        PH_POST: if (fall_w) begin
          if (cnt_q[0]) begin
            phase_q  <= PH_COMPL;
            tck_en_q <= 1'b0;
            tms_q    <= 1'b0;
          end else begin
            cnt_q <= CNT_W'(1);
            tms_q <= 1'b0;
          end
        end
        PH_WAIT: if (fall_w) begin
          if (cnt_nx == run_ext) begin
            phase_q  <= PH_COMPL;
            tck_en_q <= 1'b0;
          end else begin
            cnt_q <= cnt_nx;
          end
        end
        default: begin
          phase_q <= PH_IDLE;
          done_q  <= 1'b1;
          pass_q  <= !rej_q && (((op_q == OP_IR) || (op_q == OP_DR)) ? match_w : 1'b1);
        end
      endcase
    end
  end

  assign cmd_ready_o = phase_q == PH_IDLE;
  assign done_o      = done_q;
  assign pass_o      = pass_q;
  assign tdo_vec_o   = cap_q;
  assign tck_o       = tck_w;
  assign tms_o       = tms_q;
  assign tdi_o       = tdi_q;

  a_r1_one_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r1_busy_after_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);
  a_r2_tms_low_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tms_o) |-> !tck_o);
  a_r2_tdi_low_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tdi_o) |-> !tck_o);
  a_r5_tdi_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_SHIFT) |-> !tdi_o);
  a_r8_tck_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !tck_o);
  a_r10_end_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_COMPL && !rej_q) |-> (tap_known && tap_state == TAP_IDLE));

endmodule

// File: tb/jtag_scan_engine_tb_top.sv
module jtag_scan_engine_tb_top;
  import jtag_eng_pkg::*;

  localparam int unsigned MAX_LEN = 40;
  localparam int unsigned HALF    = 3;
  localparam int unsigned RUN_W   = 24;
  localparam int unsigned LEN_W   = $clog2(MAX_LEN + 1);

  typedef struct {
    string              tag;
    int                 op;
    int                 len;
    int                 edges;
    logic [127:0]       tms_seq;
    logic               pass;
    logic               rej;
    logic [MAX_LEN-1:0] vec;
    logic [MAX_LEN-1:0] tdi;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_op = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic [RUN_W-1:0] cmd_count = '0;
  logic [MAX_LEN-1:0] cmd_tdi = '0, cmd_exp = '0, cmd_mask = '0;
  logic done, pass;
  logic [MAX_LEN-1:0] tdo_vec;
  logic tck, tms, tdi;
  logic tdo = 1'b0;

  int n_chk = 0, n_fail = 0, n_done = 0;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  jtag_scan_engine #(.MAX_LEN(MAX_LEN), .HALF_CLKS(HALF), .RUN_W(RUN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_len_i(cmd_len), .cmd_count_i(cmd_count),
    .cmd_tdi_i(cmd_tdi), .cmd_exp_i(cmd_exp), .cmd_mask_i(cmd_mask),
    .done_o(done), .pass_o(pass), .tdo_vec_o(tdo_vec),
    .tck_o(tck), .tms_o(tms), .tdi_o(tdi), .tdo_i(tdo)
  );

  // target TAP model
  tap_e               tstate = TAP_TLR;
  logic [127:0]       tms_log;
  logic [MAX_LEN-1:0] rx_log;
  logic [MAX_LEN-1:0] src;
  int edge_cnt, rx_cnt, src_idx, tms_ones, tdi_stray;

  always @(posedge tck) begin
    if (edge_cnt < 128) tms_log[edge_cnt] = tms;
    edge_cnt = edge_cnt + 1;
    if (tms) tms_ones = tms_ones + 1;
    if (tstate == TAP_SH_DR || tstate == TAP_SH_IR) begin
      if (rx_cnt < MAX_LEN) rx_log[rx_cnt] = tdi;
      rx_cnt = rx_cnt + 1;
    end else if (tdi) begin
      tdi_stray = tdi_stray + 1;
    end
    tstate = tap_next(tstate, tms);
    if (tstate == TAP_CAP_DR || tstate == TAP_CAP_IR) src_idx = 0;
  end

  always @(negedge tck) begin
    if (tstate == TAP_SH_DR || tstate == TAP_SH_IR) begin
      tdo <= (src_idx < MAX_LEN) ? src[src_idx] : 1'b0;
      src_idx = src_idx + 1;
    end
  end

  // pin timing monitor
  int hi_run = 0, bad_phase = 0, hi_moves = 0;
  logic p_tck = 1'b0, p_tms = 1'b0, p_tdi = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (tck) hi_run = hi_run + 1;
      else if (hi_run != 0) begin
        if (hi_run != HALF) bad_phase = bad_phase + 1;
        hi_run = 0;
      end
      if (tck && p_tck && (tms != p_tms || tdi != p_tdi)) hi_moves = hi_moves + 1;
    end
    p_tck = tck; p_tms = tms; p_tdi = tdi;
  end

  task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        item_t it;
        logic [127:0] em;
        it = sb_q.pop_front();
        em = (it.edges >= 128) ? '1 : ((128'd1 << it.edges) - 128'd1);
        chk(pass == it.pass, {it.tag, " pass"}, 128'(pass), 128'(it.pass));
        chk(edge_cnt == it.edges, {it.tag, " edges"}, 128'(edge_cnt), 128'(it.edges));
        chk((tms_log & em) == it.tms_seq, {it.tag, " tms R4"}, tms_log & em, it.tms_seq);
        if (!it.rej) chk(tstate == TAP_IDLE, "R10 end in idle", 128'(tstate), 128'(TAP_IDLE));
        if (!it.rej && (it.op == 1 || it.op == 2)) begin
          logic [MAX_LEN-1:0] lm;
          lm = (it.len >= MAX_LEN) ? '1 : ((MAX_LEN'(1) << it.len) - MAX_LEN'(1));
          chk((rx_log & lm) == (it.tdi & lm), "R5 tdi lsb first", 128'(rx_log & lm), 128'(it.tdi & lm));
          chk(tdi_stray == 0, "R5 tdi quiet", 128'(tdi_stray), 128'(0));
          chk(tdo_vec == it.vec, "R6 captured vector", 128'(tdo_vec), 128'(it.vec));
        end
        if (it.op == 3) chk(tms_ones == 0, "R8 tms low in wait", 128'(tms_ones), 128'(0));
        n_done++;
      end
    end
  end

  task automatic issue(input string tag, input int op, input int len, input int cnt,
                       input logic [MAX_LEN-1:0] tdv, input logic [MAX_LEN-1:0] ex,
                       input logic [MAX_LEN-1:0] mk, input logic [MAX_LEN-1:0] srcv,
                       input logic rej);
    item_t it;
    logic [MAX_LEN-1:0] lm;
    int k, target;
    while (!cmd_ready) @(negedge clk);
    edge_cnt = 0; rx_cnt = 0; tms_ones = 0; tdi_stray = 0;
    tms_log = '0; rx_log = '0; src = srcv;
    lm = (len >= MAX_LEN) ? '1 : ((MAX_LEN'(1) << len) - MAX_LEN'(1));
    it.tag = tag; it.op = op; it.len = len; it.rej = rej; it.tdi = tdv;
    it.tms_seq = '0; it.vec = '0; it.edges = 0;
    if (rej) begin
      it.pass = 1'b0;
    end else if (op == 0) begin
      it.edges = 6; it.tms_seq = 128'h1f; it.pass = 1'b1;
    end else if (op == 3) begin
      it.edges = cnt; it.pass = 1'b1;
    end else begin
      k = (op == 1) ? 4 : 3;
      it.tms_seq = (op == 1) ? 128'h3 : 128'h1;
      it.tms_seq[k + len - 1] = 1'b1;
      it.tms_seq[k + len] = 1'b1;
      it.edges = k + len + 2;
      it.vec = srcv & lm;
      it.pass = (((srcv ^ ex) & mk & lm) == '0);
    end
    sb_q.push_back(it);
    target = n_done + 1;
    cmd_op = 2'(op); cmd_len = LEN_W'(len); cmd_count = RUN_W'(cnt);
    cmd_tdi = tdv; cmd_exp = ex; cmd_mask = mk; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R1 ready drops", 128'(cmd_ready), 128'(0));
    while (n_done != target) @(negedge clk);
  endtask

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 reset ready", 128'(cmd_ready), 128'(1));
    chk(done == 1'b0, "R1 reset done", 128'(done), 128'(0));
    chk(tck == 1'b0, "R1 reset tck", 128'(tck), 128'(0));
    chk(tdo_vec == '0, "R1 reset vector", 128'(tdo_vec), 128'(0));

    issue("R9 scan before reset", 2, 8, 0, 40'hff, '0, '0, '0, 1'b1);
    issue("R9 wait before reset", 3, 0, 5, '0, '0, '0, '0, 1'b1);
    issue("R3 reset", 0, 0, 0, '0, '0, '0, '0, 1'b0);
    issue("R4 R7 ir pass", 1, 8, 0, 40'hfe, 40'h01, 40'h03, 40'hf5_a1_c3_35, 1'b0);
    issue("R7 dr masked pass", 2, 32, 0, 40'h12_3456_789a, 40'h0_f503_6093,
          40'h0_0ffe_ffff, 40'hab_e503_6093, 1'b0);
    issue("R7 dr mismatch fail", 2, 32, 0, 40'h55_aaaa_5555, 40'h0_f503_6093,
          40'h0_0ffe_ffff, 40'h00_f503_6193, 1'b0);
    issue("R4 dr len one", 2, 1, 0, 40'h1, 40'h1, 40'h1, 40'hff_ffff_fffe, 1'b0);
    issue("R6 dr max len", 2, MAX_LEN, 0, 40'hc3_5a96_0f1e, 40'h81_7e3c_a55a,
          '1, 40'h81_7e3c_a55a, 1'b0);
    issue("R9 over length", 2, MAX_LEN + 1, 0, '1, '0, '0, '0, 1'b1);
    issue("R9 zero length", 1, 0, 0, '1, '0, '0, '0, 1'b1);
    issue("R8 wait zero", 3, 0, 0, '0, '0, '0, '0, 1'b0);
    issue("R8 wait 1000", 3, 0, 1000, '0, '0, '0, '0, 1'b0);
    issue("R4 ir after wait", 1, 16, 0, 40'hffe8, 40'h0101, 40'h0303, 40'h0101, 1'b0);
    issue("R3 second reset", 0, 0, 0, '0, '0, '0, '0, 1'b0);

    chk(bad_phase == 0, "R2 tck phase length", 128'(bad_phase), 128'(0));
    chk(hi_moves == 0, "R2 tms tdi stable high", 128'(hi_moves), 128'(0));
    chk(sb_q.size() == 0, "R1 one done per command", 128'(sb_q.size()), 128'(0));
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule